// File: doc/BRIEF.md
# Serial Two-Wire EEPROM Slave Controller

This block is the slave side of a two-wire serial bus (I2C-style framing) in front of a 2048-byte array. The bus lines are sampled with the system clock. The block finds START, STOP and clock edges and shifts bytes in and out. It drives SDA only by enabling a pull-low, as an open-drain pad would. The supported transfers are byte write, page write, current-address read, random read and sequential read.

Written bytes first collect in a 16-entry page buffer. They reach the array only when a STOP ends a write sequence. A programming timer then holds the slave busy for a set number of clock cycles, and the slave ignores its own address during that time. Two inputs block programming: a write-protect pin, and a flag from the supply supervisor that says the supply is good.

Top module: `eep_i2c_slave`

## Requirements
- R1: A byte after START is taken as a device select only when its bits 7:4 equal 4'b1010. A matching select is acknowledged (SDA pulled low during the ninth clock). Any other value leaves SDA released, and the slave stays silent until the next START.
- R2: A byte write puts one data byte at the 11-bit address. After the programming time, that byte reads back.
- R3: In a page write the low four address bits advance after each data byte and wrap inside the 16-byte page. Bytes 17 and later overwrite the earliest positions. All bytes are stored in one programming cycle.
- R4: Bits 3:1 of the device-select byte give address bits 10:8. The byte after a write select gives address bits 7:0.
- R5: A random read is a write select and address byte, then a repeated START and a read select (bit 0 = 1). It returns the byte at that address.
- R6: While the master acknowledges read bytes, the address advances through the whole array and rolls over from 2047 to 0.
- R7: A read select with no address phase returns the byte after the last one accessed.
- R8: When the write-protect input is high at STOP, data bytes are still acknowledged. The array keeps its contents, and no busy period starts.
- R9: When the supply-good input is low at STOP, programming is blocked in the same way as in R8.
- R10: A STOP that ends a write holding at least one data byte starts a busy period of exactly BUSY_CYCLES clocks. During it, a matching select is not acknowledged.
- R11: A START at any point restarts byte reception from a fresh device-select byte. It also discards data bytes loaded but not yet committed.
- R12: When the master does not acknowledge a read byte (SDA high on the ninth clock), the read ends and SDA stays released.
- R13: SDA is released in reset and when idle. The pull-low changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (wired level) |
| wp_i | input | 1 | Write protect; high blocks programming |
| supply_ok_i | input | 1 | Supply above threshold; low blocks programming |
| sda_pull_o | output | 1 | Enables the pull-low on the data line |

## Verification
The bench aims at the places where address arithmetic goes wrong. A page write of 18 bytes must land bytes 17 and 18 on page offsets 0 and 1. A design that carried into bit 4 would corrupt the next page instead. A sequential read across the top of the array must return address 0 after 2047, which catches a counter that saturates or clears the block bits. Protected writes are followed at once by a select that must be acknowledged, so a design that starts a busy period when it should not is caught. A START in the middle of a byte, and a repeated START after loaded data, must leave the array unchanged and the slave idle. A design that kept stale bits or pending data would then answer wrongly or program the array.

// File: rtl/eep_pkg.sv
package eep_pkg;
  // Byte-level protocol phases of the slave
  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_DEV_ACK,
    S_WADR,
    S_WADR_ACK,
    S_WDAT,
    S_WDAT_ACK,
    S_RDAT,
    S_RACK,
    S_RNEXT
  } eep_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int         BYTE_W   = 8;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
  parameter int STAGES = 2   // at least 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  // data edges while the clock stays high mark frame boundaries
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic [DW-1:0] ent_d [DEPTH];
  logic [DEPTH-1:0] ent_v;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_d[g] <= '0;
        ent_v[g] <= 1'b0;
      end else if (clr) begin
        ent_v[g] <= 1'b0;
      end else if (wr_en && wr_idx == IW'(g)) begin
        ent_d[g] <= wr_data;
        ent_v[g] <= 1'b1;
      end
    end
  end

  assign rd_data  = ent_d[rd_idx];
  assign rd_valid = ent_v[rd_idx];
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int BUSY_CYCLES = 2000,  // must be >= DEPTH
  parameter int DEPTH       = 16,
  localparam int CW         = $clog2(BUSY_CYCLES + 1),
  localparam int IW         = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          busy,
  output logic          walk_en,
  output logic [IW-1:0] walk_idx
);
  logic [CW-1:0] cnt;
  logic          walking;
  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      walking <= 1'b0;
      idx     <= '0;
    end else if (go) begin
      cnt     <= CW'(BUSY_CYCLES);
      walking <= 1'b1;
      idx     <= '0;
    end else begin
      if (cnt != '0) cnt <= cnt - CW'(1);
      if (walking) begin
        if (idx == IW'(DEPTH - 1)) walking <= 1'b0;
        idx <= idx + IW'(1);
      end
    end
  end

  assign busy     = (cnt != '0);
  assign walk_en  = walking;
  assign walk_idx = idx;
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
  import eep_pkg::*;
#(
  parameter int MEM_BYTES   = 2048,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  input  logic supply_ok_i,
  output logic sda_pull_o
);
  localparam int AW    = $clog2(MEM_BYTES);
  localparam int IW    = $clog2(PAGE_BYTES);
  localparam int BLK_W = AW - BYTE_W;
  localparam int PB_W  = AW - IW;

  // ---- arithmetic helpers ----
  function automatic logic dev_hit(input logic [BYTE_W-1:0] b);
    return b[7:4] == DEV_TYPE;
  endfunction

  function automatic logic [AW-1:0] addr_next_seq(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [AW-1:0] addr_next_page(input logic [AW-1:0] a);
    return {a[AW-1:IW], a[IW-1:0] + IW'(1)};
  endfunction

  function automatic logic [BLK_W-1:0] blk_of(input logic [BYTE_W-1:0] b);
    return b[BLK_W:1];
  endfunction

  // ---- bus edge detection ----
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  // ---- protocol state ----
  eep_state_e          state;
  logic [3:0]          bitcnt;
  logic [BYTE_W-1:0]   shreg;
  logic [BYTE_W-1:0]   txsr;
  logic [AW-1:0]       addr;
  logic                pend;
  logic                pull;
  logic [PB_W-1:0]     page_base;

  // ---- programming path ----
  logic          busy, walk_en, commit_go, buf_clr, buf_wr, mem_we;
  logic [IW-1:0] walk_idx;
  logic [BYTE_W-1:0] buf_rd_data;
  logic          buf_rd_valid;

  // named events, also watched by the checker
  logic byte_done, rx_phase, dev_ack_ev, nack_ev;
  logic [BYTE_W-1:0] rd_byte;

  logic [BYTE_W-1:0] mem [MEM_BYTES];

  assign byte_done  = (bitcnt == 4'd8);
  assign rx_phase   = (state == S_DEV) || (state == S_WADR) || (state == S_WDAT);
  assign dev_ack_ev = scl_fall && state == S_DEV && byte_done && dev_hit(shreg) && !busy;
  assign nack_ev    = scl_rise && state == S_RACK && sda_s;
  assign buf_wr     = scl_fall && state == S_WDAT && byte_done;
  assign buf_clr    = start_det && !busy;
  assign commit_go  = stop_det && pend && !wp_i && supply_ok_i && !busy;
  assign mem_we     = walk_en && buf_rd_valid;
  assign rd_byte    = mem[addr];

  eep_page_buf #(.DW(BYTE_W), .DEPTH(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr),
    .wr_en(buf_wr), .wr_idx(addr[IW-1:0]), .wr_data(shreg),
    .rd_idx(walk_idx), .rd_data(buf_rd_data), .rd_valid(buf_rd_valid)
  );

  eep_prog_timer #(.BUSY_CYCLES(BUSY_CYCLES), .DEPTH(PAGE_BYTES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .go(commit_go),
    .busy(busy), .walk_en(walk_en), .walk_idx(walk_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_base <= '0;
    else if (commit_go) page_base <= addr[AW-1:IW];
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[{page_base, walk_idx}] <= buf_rd_data;
  end

  // ---- byte state machine ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      txsr   <= '0;
      addr   <= '0;
      pend   <= 1'b0;
      pull   <= 1'b0;
    end else if (start_det) begin
      state  <= S_DEV;
      bitcnt <= '0;
      pull   <= 1'b0;
      pend   <= 1'b0;
    end else if (stop_det) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      pull   <= 1'b0;
      pend   <= 1'b0;
    end else if (scl_rise) begin
      if (rx_phase && !byte_done) begin
        shreg  <= {shreg[BYTE_W-2:0], sda_s};
        bitcnt <= bitcnt + 4'd1;
      end else if (state == S_RACK) begin
        state <= sda_s ? S_IDLE : S_RNEXT;
      end
    end else if (scl_fall) begin
      case (state)
        S_DEV: if (byte_done) begin
          if (dev_ack_ev) begin
            pull  <= 1'b1;
            state <= S_DEV_ACK;
            if (!shreg[0]) addr[AW-1:BYTE_W] <= blk_of(shreg);
          end else begin
            state <= S_IDLE;
          end
        end
        S_DEV_ACK: begin
          bitcnt <= '0;
          if (shreg[0]) begin
            txsr   <= rd_byte;
            pull   <= ~rd_byte[BYTE_W-1];
            addr   <= addr_next_seq(addr);
            bitcnt <= 4'd1;
            state  <= S_RDAT;
          end else begin
            pull  <= 1'b0;
            state <= S_WADR;
          end
        end
        S_WADR: if (byte_done) begin
          addr[BYTE_W-1:0] <= shreg;
          pull  <= 1'b1;
          state <= S_WADR_ACK;
        end
        S_WADR_ACK: begin
          pull   <= 1'b0;
          bitcnt <= '0;
          state  <= S_WDAT;
        end
        S_WDAT: if (byte_done) begin
          addr  <= addr_next_page(addr);
          pend  <= 1'b1;
          pull  <= 1'b1;
          state <= S_WDAT_ACK;
        end
        S_WDAT_ACK: begin
          pull   <= 1'b0;
          bitcnt <= '0;
          state  <= S_WDAT;
        end
        S_RDAT: begin
          if (!byte_done) begin
            pull   <= ~txsr[BYTE_W-2];
            txsr   <= {txsr[BYTE_W-2:0], 1'b0};
            bitcnt <= bitcnt + 4'd1;
          end else begin
            pull  <= 1'b0;
            state <= S_RACK;
          end
        end
        S_RNEXT: begin
          txsr   <= rd_byte;
          pull   <= ~rd_byte[BYTE_W-1];
          addr   <= addr_next_seq(addr);
          bitcnt <= 4'd1;
          state  <= S_RDAT;
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o = pull;
endmodule

// File: rtl/eep_i2c_chk.sv
module eep_i2c_chk #(
  parameter int BUSY_CYCLES = 2000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_pull_o,
  input logic       busy,
  input logic       dev_ack_ev,
  input logic       nack_ev,
  input logic       start_det,
  input logic [7:0] shreg,
  input logic [3:0] state,
  input logic [3:0] bitcnt,
  input logic       mem_we,
  input logic       wp_i,
  input logic       supply_ok_i
);
  logic [31:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= '0;
    else if (busy) busy_run <= busy_run + 32'd1;
    else busy_run <= '0;
  end

  a_r13_pull_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_pull_o));

  a_r10_no_select_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dev_ack_ev);

  a_r10_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_run == BUSY_CYCLES);

  a_r1_ack_needs_type: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack_ev |-> shreg[7:4] == 4'b1010);

  a_r8_prog_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!wp_i && supply_ok_i));

  a_r3_store_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  a_r11_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == eep_pkg::S_DEV && bitcnt == 4'd0));

  a_r12_nack_releases: assert property (@(posedge clk) disable iff (!rst_n)
    nack_ev |=> !sda_pull_o);
endmodule

bind eep_i2c_slave eep_i2c_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull_o(sda_pull_o),
  .busy(busy), .dev_ack_ev(dev_ack_ev), .nack_ev(nack_ev),
  .start_det(start_det), .shreg(shreg), .state(state), .bitcnt(bitcnt),
  .mem_we(mem_we), .wp_i(wp_i), .supply_ok_i(supply_ok_i)
);

// File: tb/sim_eep_i2c_slave.sv
module sim_eep_i2c_slave;
  localparam int MEMB = 2048;
  localparam int BUSY = 2000;
  localparam int Q    = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, scl_m, sda_m, wp, sok, pull;
  wire  sda_line = sda_m & ~pull;

  eep_i2c_slave #(.MEM_BYTES(MEMB), .PAGE_BYTES(16), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .wp_i(wp), .supply_ok_i(sok), .sda_pull_o(pull)
  );

  int checks = 0, errors = 0;
  logic [7:0] refm [MEMB];
  logic [7:0] wdat [32];
  typedef struct { logic [7:0] d; string tag; } exp_t;
  exp_t       expq[$];
  logic [7:0] gotq[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---- bus master ----
  task automatic i2c_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = ~sda_line;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl_m = 1'b1; tick(Q);
      b = {b[6:0], sda_line};
      tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = ~mack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] dev(input int a, input bit rd);
    return {4'b1010, 3'(a >> 8), rd};
  endfunction

  // driver: write wdat[0..n-1] starting at a
  task automatic write_seq(input int a, input int n, input bit commit, input string tag);
    bit ack;
    i2c_start();
    send_byte(dev(a, 0), ack);  chk(ack, {tag, " select ack"}, ack, 1);
    send_byte(8'(a), ack);      chk(ack, {tag, " addr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wdat[i], ack);  chk(ack, {tag, " data ack"}, ack, 1);
    end
    i2c_stop();
    if (commit) begin
      for (int i = 0; i < n; i++) refm[(a & ~15) | ((a + i) & 15)] = wdat[i];
      tick(BUSY + 100);
    end else tick(4*Q);
  endtask

  // driver: random/sequential read; pushes expected bytes into the scoreboard
  task automatic read_rand(input int a, input int n, input int extra, input string tag);
    bit ack; logic [7:0] b;
    i2c_start();
    send_byte(dev(a, 0), ack);  chk(ack, {tag, " select ack"}, ack, 1);
    send_byte(8'(a), ack);      chk(ack, {tag, " addr ack"}, ack, 1);
    i2c_start();
    send_byte(dev(0, 1), ack);  chk(ack, {tag, " read select ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      expq.push_back('{refm[(a + i) % MEMB], tag});
      recv_byte(i != n - 1, b);
      gotq.push_back(b);
    end
    for (int k = 0; k < extra; k++) begin  // R12: released after NACK
      tick(Q); scl_m = 1'b1;
      for (int j = 0; j < 2*Q; j++) begin
        tick(1); chk(pull == 1'b0, "R12 released after nack", pull, 0);
      end
      scl_m = 1'b0; tick(Q);
    end
    i2c_stop();
    tick(4*Q);
  endtask

  task automatic read_current(input int exp_a, input string tag);
    bit ack; logic [7:0] b;
    i2c_start();
    send_byte(dev(0, 1), ack); chk(ack, {tag, " read select ack"}, ack, 1);
    expq.push_back('{refm[exp_a % MEMB], tag});
    recv_byte(1'b0, b);
    gotq.push_back(b);
    i2c_stop();
    tick(4*Q);
  endtask

  task automatic probe_select(input bit exp_ack, input string tag);
    bit ack;
    i2c_start();
    send_byte(dev(0, 0), ack);
    chk(ack == exp_ack, tag, ack, exp_ack);
    i2c_stop();
    tick(4*Q);
  endtask

  // monitor: pops results and compares them with the expected queue
  initial begin
    forever begin
      @(negedge clk);
      while (gotq.size() > 0) begin
        logic [7:0] g;
        g = gotq.pop_front();
        if (expq.size() == 0) chk(1'b0, "scoreboard underflow", g, 0);
        else begin
          exp_t e;
          e = expq.pop_front();
          chk(g === e.d, e.tag, g, e.d);
        end
      end
    end
  end

  task automatic finish_run();
    tick(4);
    chk(expq.size() == 0, "scoreboard drained", expq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    for (int i = 0; i < MEMB; i++) refm[i] = 8'h00;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; wp = 1'b0; sok = 1'b1;
    tick(5);
    chk(pull == 1'b0, "R13 released in reset", pull, 0);
    rst_n = 1'b1; tick(5);
    chk(pull == 1'b0, "R13 released when idle", pull, 0);

    // R2 + R5: byte write and random read
    wdat[0] = 8'hA5;
    write_seq(11'h235, 1, 1'b1, "R2 byte write");
    read_rand(11'h235, 1, 0, "R5 random read");

    // R1: wrong device type is not acknowledged
    i2c_start();
    send_byte(8'hB0, ack);
    chk(!ack, "R1 foreign select nack", ack, 0);
    i2c_stop(); tick(4*Q);

    // R4: block bits select address 10:8
    wdat[0] = 8'h3C; write_seq(11'h510, 1, 1'b1, "R4 block5");
    wdat[0] = 8'hC3; write_seq(11'h010, 1, 1'b1, "R4 block0");
    read_rand(11'h510, 1, 0, "R4 read block5");
    read_rand(11'h010, 1, 0, "R4 read block0");

    // R3: 18-byte page write wraps within the page
    wdat[0] = 8'h77; write_seq(11'h150, 1, 1'b1, "R3 next page");
    for (int i = 0; i < 18; i++) wdat[i] = 8'(8'h10 + i);
    write_seq(11'h140, 18, 1'b1, "R3 page wrap");
    read_rand(11'h140, 16, 0, "R3 page contents");
    // R7: current address follows the last byte read
    read_current(11'h150, "R7 current read");

    // R6: sequential read rolls over the top of the array
    wdat[0] = 8'hE1; wdat[1] = 8'hE2; write_seq(11'h7FE, 2, 1'b1, "R6 top");
    wdat[0] = 8'h5A; write_seq(11'h000, 1, 1'b1, "R6 bottom");
    read_rand(11'h7FE, 3, 0, "R6 rollover read");

    // R8: write protect
    wp = 1'b1;
    wdat[0] = 8'h00; write_seq(11'h235, 1, 1'b0, "R8 protected");
    probe_select(1'b1, "R8 no busy after protected write");
    wp = 1'b0;
    read_rand(11'h235, 1, 0, "R8 array unchanged");

    // R9: supply lockout
    sok = 1'b0;
    wdat[0] = 8'h11; write_seq(11'h235, 1, 1'b0, "R9 lockout");
    probe_select(1'b1, "R9 no busy under lockout");
    sok = 1'b1;
    read_rand(11'h235, 1, 0, "R9 array unchanged");

    // R10: busy window ignores the select
    wdat[0] = 8'h99;
    write_seq(11'h300, 1, 1'b0, "R10 write");
    probe_select(1'b0, "R10 select ignored while busy");
    tick(BUSY);
    probe_select(1'b1, "R10 select answered after busy");
    refm[11'h300] = 8'h99;
    read_rand(11'h300, 1, 0, "R10 stored");

    // R11: START inside a byte restarts reception
    i2c_start();
    send_byte(dev(11'h300, 0), ack); chk(ack, "R11 select ack", ack, 1);
    send_bits(8'hFF, 4);
    read_rand(11'h300, 1, 0, "R11 after mid-byte start");
    // R11: repeated START discards loaded data
    i2c_start();
    send_byte(dev(11'h320, 0), ack); chk(ack, "R11 select ack 2", ack, 1);
    send_byte(8'h20, ack);           chk(ack, "R11 addr ack", ack, 1);
    send_byte(8'h44, ack);           chk(ack, "R11 data ack", ack, 1);
    i2c_start();
    i2c_stop(); tick(4*Q);
    probe_select(1'b1, "R11 no programming after restart");

    // R12: master NACK ends the read, SDA stays released
    read_rand(11'h235, 1, 2, "R12 read then nack");

    finish_run();
  end
endmodule